// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Path Registering

A single-clock first-in first-out buffer with one writer and one reader. The writer offers an item by raising `wr_put` with `wr_data`. The item is taken on a rising clock edge where `wr_ready` is high. The reader sees `rd_request` whenever an item is available. It can look at the head item on `rd_data` at any time, and it consumes that item by raising `rd_get` while `rd_request` is high.

Two build-time switches choose the timing of the two directions on their own:

- `SYNC_VALID` puts a register stage on the write path before storage. This adds one cycle of latency.
- `SYNC_READY` makes `wr_ready` a flop, which removes the combinational path from `rd_get` to `wr_ready`.

Two further switches control the optional outputs and reset:

- `USE_LEVEL` enables an element count and an almost-full flag.
- `CLEAR_ON_RESET` zeroes every storage entry during reset.

With both switches of the first group off, the FIFO can be placed between two combinational processes and accepts a write into a full buffer in the same cycle as a read.

Top module: `lat_fifo`

## Requirements
- R1: During and right after reset, `wr_ready` is 1, `rd_request` is 0, `rd_data` is all zeros, and `level` and `almost_full` are 0.
- R2: Items leave in the order they were accepted. An item is accepted at an edge where `wr_put && wr_ready`, and removed at an edge where `rd_get && rd_request`. While `rd_request` is high, `rd_data` shows the oldest stored item.
- R3: The FIFO never holds more than `DEPTH` items. A `wr_put` while `wr_ready` is low changes nothing.
- R4: An `rd_get` while `rd_request` is low changes nothing. While empty, `rd_data` keeps showing the item that was presented last, or zero if nothing has been presented since reset.
- R5: `level` is the number of items in storage after the last edge. `rd_request` is high exactly when that number is nonzero. `almost_full` is high when `level >= DEPTH - AF_GAP`. An item accepted at edge k counts in storage from edge k when `SYNC_VALID`=0, and from edge k+1 when `SYNC_VALID`=1.
- R6: With `SYNC_READY`=0, `wr_ready` is high when occupancy is below `DEPTH`, or when a get is being taken in the same cycle. Occupancy means stored items plus any item held in the write register stage. A put and a get on a full FIFO are therefore both taken.
- R7: With `SYNC_READY`=1, `wr_ready` is a flop that is high exactly when the occupancy left by the previous edge is below `DEPTH`. It ignores a get in the current cycle.
- R8: When `DEPTH >= 1 + SYNC_VALID + SYNC_READY`, a writer that puts every cycle into an initially empty FIFO sees `wr_ready` high on every cycle, provided the reader gets whenever `rd_request` is high.
- R9: With `USE_LEVEL`=0, `level` and `almost_full` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_put | input | 1 | Writer offers an item |
| wr_data | input | WIDTH | Item offered by the writer |
| wr_ready | output | 1 | Writer's item is taken at this edge if offered |
| rd_request | output | 1 | An item is available to the reader |
| rd_data | output | WIDTH | Head item, or last presented item while empty |
| rd_get | input | 1 | Reader consumes the head item |
| level | output | clog2(DEPTH+1) | Stored item count as of the last edge |
| almost_full | output | 1 | Count has reached DEPTH-AF_GAP |

## Verification
Some properties are checked on every cycle:
- the reset state of the handshake;
- that `rd_data` holds while the FIFO is empty;
- that `level` never exceeds `DEPTH`, and that a full FIFO refuses a lone put;
- the two full-buffer behaviours of `wr_ready`: a same-cycle swap when the ready path is combinational, and a refusal when it is registered;
- that a lone get lowers `level` by one.

Other behaviours only the scenarios can show:
- ordering across the write register stage;
- exactly `DEPTH` acceptances during a fill;
- the one-edge extra latency of `rd_request` when the write path is registered;
- sustained one-per-cycle streaming in all four path combinations;
- the zeroed optional outputs.

// File: rtl/lat_fifo_pkg.sv
package lat_fifo_pkg;

  // Width of a read/write index into DEPTH entries
  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Width of a counter that can hold 0..DEPTH
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/lat_fifo_store.sv
module lat_fifo_store #(
  parameter int DEPTH          = 4,
  parameter int WIDTH          = 8,
  parameter bit CLEAR_ON_RESET = 1'b0
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_en,
  input  logic [WIDTH-1:0]                         wr_data,
  input  logic                                     rd_en,
  output logic [lat_fifo_pkg::cnt_bits(DEPTH)-1:0] count,
  output logic [WIDTH-1:0]                         head
);
  localparam int PW = lat_fifo_pkg::ptr_bits(DEPTH);
  localparam int CW = lat_fifo_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] last_q;
  logic             rd_ok, wr_ok, has_item;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign has_item = (count_q != '0);
  assign rd_ok    = rd_en && has_item;
  assign wr_ok    = wr_en && ((count_q != FULL_CNT) || rd_ok);

  // Storage array: reset clearing only when requested, so that
  // the plain variant maps onto RAM without a reset port.
  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
          mem[wptr_q] <= wr_data;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) rptr_q <= bump(rptr_q);
      count_q <= count_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  // Remembers the item on display so an empty FIFO keeps showing it
  always_ff @(posedge clk) begin
    if (rst)           last_q <= '0;
    else if (has_item) last_q <= mem[rptr_q];
  end

  assign head  = has_item ? mem[rptr_q] : last_q;
  assign count = count_q;

endmodule

// File: rtl/lat_fifo_ready.sv
module lat_fifo_ready #(
  parameter int DEPTH      = 4,
  parameter bit SYNC_READY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_put,
  input  logic rd_fire,
  output logic wr_ready
);
  localparam int CW = lat_fifo_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Occupancy: stored items plus the one in the write stage, if any
  logic [CW-1:0] occ_q, occ_next;
  logic          put_fire;

  assign put_fire = wr_put && wr_ready;
  assign occ_next = occ_q + CW'(put_fire) - CW'(rd_fire);

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_next;
  end

  generate
    if (SYNC_READY) begin : g_flop
      logic rdy_q;
      always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b1;
        else     rdy_q <= (occ_next < FULL_CNT);
      end
      assign wr_ready = rdy_q;
    end else begin : g_comb
      assign wr_ready = (occ_q < FULL_CNT) || rd_fire;
    end
  endgenerate

endmodule

// File: rtl/lat_fifo.sv
module lat_fifo #(
  parameter int DEPTH          = 4,
  parameter int WIDTH          = 8,
  parameter bit SYNC_VALID     = 1'b0,
  parameter bit SYNC_READY     = 1'b0,
  parameter bit USE_LEVEL      = 1'b1,
  parameter bit CLEAR_ON_RESET = 1'b0,
  parameter int AF_GAP         = 1
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_put,
  input  logic [WIDTH-1:0]                         wr_data,
  output logic                                     wr_ready,
  output logic                                     rd_request,
  output logic [WIDTH-1:0]                         rd_data,
  input  logic                                     rd_get,
  output logic [lat_fifo_pkg::cnt_bits(DEPTH)-1:0] level,
  output logic                                     almost_full
);
  localparam int CW = lat_fifo_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] AF_CNT = CW'(DEPTH - AF_GAP);

  logic             put_fire, rd_fire;
  logic             core_wr;
  logic [WIDTH-1:0] core_data;
  logic [CW-1:0]    count;

  assign put_fire   = wr_put && wr_ready;
  assign rd_request = (count != '0);
  assign rd_fire    = rd_get && rd_request;

  // Write path: direct, or through one register stage
  generate
    if (SYNC_VALID) begin : g_wstage
      logic             stg_v;
      logic [WIDTH-1:0] stg_d;
      always_ff @(posedge clk) begin
        if (rst) stg_v <= 1'b0;
        else     stg_v <= put_fire;
      end
      always_ff @(posedge clk) begin
        if (put_fire) stg_d <= wr_data;
      end
      assign core_wr   = stg_v;
      assign core_data = stg_d;
    end else begin : g_wdirect
      assign core_wr   = put_fire;
      assign core_data = wr_data;
    end
  endgenerate

  lat_fifo_store #(
    .DEPTH         (DEPTH),
    .WIDTH         (WIDTH),
    .CLEAR_ON_RESET(CLEAR_ON_RESET)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (core_wr),
    .wr_data(core_data),
    .rd_en  (rd_fire),
    .count  (count),
    .head   (rd_data)
  );

  lat_fifo_ready #(
    .DEPTH     (DEPTH),
    .SYNC_READY(SYNC_READY)
  ) u_ready (
    .clk     (clk),
    .rst     (rst),
    .wr_put  (wr_put),
    .rd_fire (rd_fire),
    .wr_ready(wr_ready)
  );

  generate
    if (USE_LEVEL) begin : g_level
      assign level       = count;
      assign almost_full = (count >= AF_CNT);
    end else begin : g_nolevel
      assign level       = '0;
      assign almost_full = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lat_fifo_props.sv
module lat_fifo_props #(
  parameter int DEPTH      = 4,
  parameter int WIDTH      = 8,
  parameter bit SYNC_VALID = 1'b0,
  parameter bit SYNC_READY = 1'b0,
  parameter bit USE_LEVEL  = 1'b1
) (
  input logic                                     clk,
  input logic                                     rst,
  input logic                                     wr_put,
  input logic                                     wr_ready,
  input logic                                     rd_request,
  input logic [WIDTH-1:0]                         rd_data,
  input logic                                     rd_get,
  input logic [lat_fifo_pkg::cnt_bits(DEPTH)-1:0] level
);
  localparam int CW = lat_fifo_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wr_ready && !rd_request && (rd_data == '0)));

  a_r4_peek_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_request |=> (rd_request || $stable(rd_data)));

  generate
    if (USE_LEVEL) begin : g_lvl
      a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_CNT);

      a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ((level == FULL_CNT) && !rd_get) |-> !wr_ready);

      if (SYNC_READY) begin : g_sr
        a_r7_full_refuses: assert property (@(posedge clk) disable iff (rst)
          (level == FULL_CNT) |-> !wr_ready);
      end

      if (!SYNC_VALID) begin : g_sv0
        a_r2_pop_level: assert property (@(posedge clk) disable iff (rst)
          (rd_get && rd_request && !(wr_put && wr_ready))
          |=> (level == $past(level) - 1'b1));

        if (!SYNC_READY) begin : g_swap
          a_r6_full_swap: assert property (@(posedge clk) disable iff (rst)
            ((level == FULL_CNT) && rd_get) |-> wr_ready);
        end
      end
    end
  endgenerate

endmodule

bind lat_fifo lat_fifo_props #(
  .DEPTH     (DEPTH),
  .WIDTH     (WIDTH),
  .SYNC_VALID(SYNC_VALID),
  .SYNC_READY(SYNC_READY),
  .USE_LEVEL (USE_LEVEL)
) u_props (
  .clk       (clk),
  .rst       (rst),
  .wr_put    (wr_put),
  .wr_ready  (wr_ready),
  .rd_request(rd_request),
  .rd_data   (rd_data),
  .rd_get    (rd_get),
  .level     (level)
);

// File: tb/lat_fifo_test.sv
module lat_fifo_test;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int GAP   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_fail   = 0;
  logic [3:0] done = '0;

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input int cfg, input bit ok, input string rq,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cfg=%0d actual=%0h expected=%0h", rq, cfg, act, exp);
    end
  endtask

  for (genvar g = 0; g < 4; g++) begin : cfg
    localparam bit SV  = g[0];
    localparam bit SR  = g[1];
    localparam bit LVL = (g != 2);

    logic             put = 1'b0, get = 1'b0;
    logic [WIDTH-1:0] data = '0;
    logic             ready, req, af;
    logic [WIDTH-1:0] rdata;
    logic [2:0]       lvl;
    logic [WIDTH-1:0] sb[$];
    bit               active = 1'b0;
    int               n_acc = 0;

    lat_fifo #(
      .DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_VALID(SV), .SYNC_READY(SR),
      .USE_LEVEL(LVL), .CLEAR_ON_RESET(g == 3), .AF_GAP(GAP)
    ) uut (
      .clk(clk), .rst(rst), .wr_put(put), .wr_data(data), .wr_ready(ready),
      .rd_request(req), .rd_data(rdata), .rd_get(get), .level(lvl),
      .almost_full(af)
    );

    // Driver: applies one cycle of stimulus, records accepted items
    task automatic step(input bit p, input bit q, input logic [WIDTH-1:0] d);
      @(negedge clk);
      put = p; get = q; data = d;
      #1;
      if (put && ready) begin sb.push_back(data); n_acc++; end
    endtask

    initial begin
      wait (rst == 1'b0);
      #2;
      check(g, ready == 1'b1, "R1 ready", ready, 1);
      check(g, req == 1'b0, "R1 request", req, 0);
      check(g, rdata == '0, "R1 data", rdata, 0);
      check(g, lvl == '0 && af == 1'b0, "R1 level", lvl, 0);
      active = 1'b1;
      // Fill past capacity
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'(8'h10 + i));
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0);
      check(g, n_acc == DEPTH, "R3 accepted", n_acc, DEPTH);
      // Put and get together while full
      @(negedge clk);
      put = 1'b1; get = 1'b1; data = 8'h55;
      #1;
      if (SR) check(g, ready == 1'b0, "R7 full swap refused", ready, 0);
      else    check(g, ready == 1'b1, "R6 full swap taken", ready, 1);
      if (put && ready) sb.push_back(data);
      // Drain, then get on empty
      for (int i = 0; i < 8; i++) step(1'b0, 1'b1, '0);
      check(g, sb.size() == 0, "R2 drained", sb.size(), 0);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b1, '0);
      check(g, rdata == (SR ? 8'h13 : 8'h55), "R4 empty peek", rdata,
            SR ? 8'h13 : 8'h55);
      // Latency of a single item
      step(1'b1, 1'b0, 8'hA5);
      step(1'b0, 1'b0, '0);
      check(g, req == !SV, "R5 latency edge1", req, !SV);
      step(1'b0, 1'b0, '0);
      check(g, req == 1'b1, "R5 latency edge2", req, 1);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);
      // Streaming
      begin
        int n_low = 0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          put = 1'b1; get = 1'b1; data = 8'(8'h80 + i);
          #1;
          if (!ready) n_low++;
          if (put && ready) sb.push_back(data);
        end
        check(g, n_low == 0, "R8 ready stalls", n_low, 0);
      end
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '0);
      check(g, sb.size() == 0, "R2 stream drained", sb.size(), 0);
      step(1'b0, 1'b0, '0);
      active = 1'b0;
      done[g] = 1'b1;
    end

    // Monitor: reference occupancy model and scoreboard compare
    int               m_occ = 0, m_cnt = 0;
    bit               m_stg = 0, m_rdy = 1;
    logic [WIDTH-1:0] m_last = '0;

    always @(negedge clk) begin
      #2;
      if (active) begin
        bit acc, pop, exp_rdy;
        acc = put && ready;
        pop = get && req;
        check(g, req == (m_cnt != 0), "R5 request", req, m_cnt != 0);
        if (LVL) begin
          check(g, lvl == 3'(m_cnt), "R5 level", lvl, m_cnt);
          check(g, af == (m_cnt >= DEPTH - GAP), "R5 almost_full", af,
                m_cnt >= DEPTH - GAP);
        end else begin
          check(g, lvl == '0 && af == 1'b0, "R9 level off", {af, lvl}, 0);
        end
        exp_rdy = SR ? m_rdy : ((m_occ < DEPTH) || pop);
        check(g, ready == exp_rdy, SR ? "R7 ready" : "R6 ready", ready, exp_rdy);
        if (pop) begin
          if (sb.size() == 0) begin
            check(g, 1'b0, "R2 unexpected item", rdata, 0);
          end else begin
            check(g, rdata == sb[0], "R2 order", rdata, sb[0]);
            m_last = sb.pop_front();
          end
        end else if (!req) begin
          check(g, rdata == m_last, "R4 hold", rdata, m_last);
        end
        begin
          int occ_n;
          occ_n = m_occ + int'(acc) - int'(pop);
          m_cnt = m_cnt + (SV ? int'(m_stg) : int'(acc)) - int'(pop);
          m_stg = acc;
          m_rdy = (occ_n < DEPTH);
          m_occ = occ_n;
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      wait (&done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", done, 4'hF);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule